// File: doc/BRIEF.md
# Low-Speed USB Token Receive Filter

This block is the receive side of a low-speed USB device interface. It samples the two bus lines at four times the 1.5 Mbit/s bit rate and recovers the bit timing from the edges it sees. It then finds the start-of-packet pattern, undoes NRZI coding and bit stuffing, and assembles bytes. Each received byte is delivered on a simple valid-qualified byte stream, and a flag marks a packet that ends cleanly.

Token packets (OUT, IN, SETUP) are also checked against an 8-bit configuration register. That register holds an enable flag and a 7-bit device address. A token whose PID, CRC5, address and endpoint all check out produces a single-cycle accept strobe carrying the token kind and the endpoint number. A disabled block stays silent: it gives no accept strobe and no bytes. The analog transceiver, the transmit side, handshakes, data CRC16 and FIFOs are not part of this block.

Top module: `usb_ls_token_rx`

## Requirements
- R1: Bus states are J = {dp,dm} 01, K = 10 and SE0 = 00, with 4 clock samples per bit. The bit sample point is realigned on every observed line change. Bits stretched or shortened by one sample, alternating 5 and 3 samples, are still received correctly.
- R2: A packet starts only after a decoded run of at least 3 zeros followed by a decoded 1 on two successive K bits. Without such a start pattern, no byte and no end flag are produced.
- R3: Decoded data is NRZI (no line change = 1, change = 0) and is assembled LSB first. Each complete byte appears on byte_data_o with a one-cycle byte_valid_o.
- R4: After six consecutive decoded 1s, the next bit is a stuffed 0 and is removed from the data. If that bit is a 1 instead, the packet is dropped: no further bytes, no end flag and no token accept.
- R5: When the enable flag (configuration bit 7) is clear, tok_valid_o and byte_valid_o stay low for every packet.
- R6: Reset clears the configuration register to 0x00. cfg_o reads back the value last written through cfg_wr_i and cfg_wdata_i.
- R7: Only tokens naming endpoint 0, 1 or 2 are accepted. tok_ep_o reports that endpoint number.
- R8: A token is accepted only if it is exactly three bytes long and its PID byte has an upper nibble equal to the bitwise complement of the lower nibble. The lower nibble must also be 0001 (OUT, tok_type_o = 0), 1001 (IN, 1) or 1101 (SETUP, 2).
- R9: The 16 bits after the PID must leave the CRC5 residual 01100 (polynomial x^5+x^2+1, register preset to all ones), or the token is ignored. Those 16 bits are the address in bits 6..0, the endpoint in bits 10..7 and the CRC in bits 15..11.
- R10: The token's address field must equal configuration bits 6..0 for the token to be accepted.
- R11: End of packet is at least two bit times of SE0 followed by J. byte_eop_o pulses once when the packet ended on a byte boundary. A packet that ends mid-byte gives no end flag and no token accept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, four cycles per bus bit |
| rst | input | 1 | Synchronous active-high reset |
| dp_i | input | 1 | D+ line sample |
| dm_i | input | 1 | D- line sample |
| cfg_wr_i | input | 1 | Write strobe for the configuration register |
| cfg_wdata_i | input | 8 | Configuration value: bit 7 enable, bits 6..0 address |
| cfg_o | output | 8 | Current configuration register value |
| tok_valid_o | output | 1 | One-cycle token-accepted strobe |
| tok_type_o | output | 2 | Token kind: 0 OUT, 1 IN, 2 SETUP |
| tok_ep_o | output | 2 | Endpoint number of the accepted token |
| byte_valid_o | output | 1 | One-cycle strobe for a received byte |
| byte_data_o | output | 8 | Received byte |
| byte_eop_o | output | 1 | One-cycle flag for a packet ended on a byte boundary |

## Verification
The hardest states to reach from the ports are the ones that depend on exact bit-level line shapes. These are a seventh consecutive 1 where a stuffed 0 belongs, a packet that stops three bits into a byte, and edges that arrive one sample early or late. The bench builds every packet from a bit list with its own NRZI and stuffing encoder. That encoder can skip stuffing, cut the stream at any bit, shorten the start pattern, or alternate 5- and 3-sample bit widths. This reaches each of those states with otherwise legal packets. The address and endpoint values in the vector table are chosen so that runs of ones force stuffed bits into the token fields.

// File: rtl/usb_ls_rx_pkg.sv
package usb_ls_rx_pkg;

  // line state encoded as {dp, dm}
  typedef enum logic [1:0] {
    LS_SE0 = 2'b00,
    LS_J   = 2'b01,
    LS_K   = 2'b10,
    LS_SE1 = 2'b11
  } line_t;

  typedef enum logic [1:0] {
    TK_OUT   = 2'd0,
    TK_IN    = 2'd1,
    TK_SETUP = 2'd2,
    TK_NONE  = 2'd3
  } tok_kind_t;

  // token layout after the PID: address, endpoint, crc5
  localparam int TOK_ADDR_W  = 7;
  localparam int TOK_EP_W    = 4;
  localparam int TOK_CRC_W   = 5;
  localparam int TOK_FIELD_W = TOK_ADDR_W + TOK_EP_W + TOK_CRC_W;

  localparam logic [3:0] PID_OUT   = 4'b0001;
  localparam logic [3:0] PID_IN    = 4'b1001;
  localparam logic [3:0] PID_SETUP = 4'b1101;

  localparam logic [4:0] CRC5_POLY     = 5'b00101;
  localparam logic [4:0] CRC5_RESIDUAL = 5'b01100;

endpackage

// File: rtl/usb_ls_line_sampler.sv
module usb_ls_line_sampler
  import usb_ls_rx_pkg::*;
#(
  parameter int SPB = 4
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  dp_i,
  input  logic  dm_i,
  output line_t ls_o,
  output logic  bit_stb_o
);

  localparam int CW = (SPB > 2) ? $clog2(SPB) : 1;
  localparam logic [CW-1:0] PH_LAST = CW'(SPB - 1);
  localparam logic [CW-1:0] PH_MID  = CW'(SPB / 2);

  logic [1:0]    sync1, sync2;
  line_t         cur;
  logic [CW-1:0] ph, ph_n;
  logic          edge_seen;

  assign edge_seen = (line_t'(sync2) != cur);

  always_comb begin
    if (edge_seen)           ph_n = '0;
    else if (ph == PH_LAST)  ph_n = '0;
    else                     ph_n = ph + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sync1     <= 2'b01;
      sync2     <= 2'b01;
      cur       <= LS_J;
      ph        <= '0;
      ls_o      <= LS_J;
      bit_stb_o <= 1'b0;
    end else begin
      sync1     <= {dp_i, dm_i};
      sync2     <= sync1;
      cur       <= line_t'(sync2);
      ph        <= ph_n;
      ls_o      <= line_t'(sync2);
      bit_stb_o <= (ph_n == PH_MID);
    end
  end

  AST_STB_GAP: assert property (@(posedge clk) disable iff (rst)
    bit_stb_o |=> !bit_stb_o); // R1

endmodule

// File: rtl/usb_ls_bit_decoder.sv
module usb_ls_bit_decoder
  import usb_ls_rx_pkg::*;
#(
  parameter int STUFF_RUN = 6,
  parameter int SYNC_MIN_ZEROS = 3
) (
  input  logic       clk,
  input  logic       rst,
  input  line_t      ls_i,
  input  logic       bit_stb_i,
  output logic       pkt_start_o,
  output logic       byte_stb_o,
  output logic [7:0] byte_o,
  output logic       eop_o
);

  localparam int OW = $clog2(STUFF_RUN + 1);
  localparam logic [OW-1:0] RUN_MAX = OW'(STUFF_RUN);
  localparam logic [2:0]    ZMIN    = 3'(SYNC_MIN_ZEROS);

  typedef enum logic [2:0] {
    ST_IDLE, ST_SYNC, ST_DATA, ST_EOP, ST_DROP
  } dec_st_t;

  dec_st_t       st;
  line_t         prev;
  logic [2:0]    zeros;
  logic [OW-1:0] ones;
  logic [2:0]    bitcnt;
  logic [7:0]    sh;
  logic [1:0]    se0cnt;
  logic          dec;

  assign dec = (ls_i == prev);

  always_ff @(posedge clk) begin
    byte_stb_o  <= 1'b0;
    eop_o       <= 1'b0;
    pkt_start_o <= 1'b0;
    if (rst) begin
      st     <= ST_IDLE;
      prev   <= LS_J;
      zeros  <= '0;
      ones   <= '0;
      bitcnt <= '0;
      sh     <= '0;
      se0cnt <= '0;
      byte_o <= '0;
    end else if (bit_stb_i) begin
      case (st)
        ST_IDLE: begin
          if (ls_i == LS_K) begin
            st    <= ST_SYNC;
            zeros <= 3'd1;
            prev  <= LS_K;
          end else begin
            prev <= LS_J;
          end
        end
        ST_SYNC: begin
          if (ls_i == LS_SE0 || ls_i == LS_SE1) begin
            st     <= ST_DROP;
            se0cnt <= (ls_i == LS_SE0) ? 2'd1 : 2'd0;
          end else begin
            prev <= ls_i;
            if (!dec) begin
              if (zeros != 3'd7) zeros <= zeros + 3'd1;
            end else if (ls_i == LS_K && zeros >= ZMIN) begin
              st          <= ST_DATA;
              ones        <= OW'(1);
              bitcnt      <= '0;
              pkt_start_o <= 1'b1;
            end else begin
              st <= ST_IDLE;
            end
          end
        end
        ST_DATA: begin
          if (ls_i == LS_SE0) begin
            st     <= ST_EOP;
            se0cnt <= 2'd1;
          end else if (ls_i == LS_SE1) begin
            st     <= ST_DROP;
            se0cnt <= 2'd0;
          end else begin
            prev <= ls_i;
            if (ones == RUN_MAX) begin
              if (dec) begin
                st     <= ST_DROP;
                se0cnt <= 2'd0;
              end else begin
                ones <= '0;
              end
            end else begin
              sh     <= {dec, sh[7:1]};
              ones   <= dec ? ones + 1'b1 : '0;
              bitcnt <= bitcnt + 3'd1;
              if (bitcnt == 3'd7) begin
                byte_stb_o <= 1'b1;
                byte_o     <= {dec, sh[7:1]};
              end
            end
          end
        end
        ST_EOP: begin
          if (ls_i == LS_SE0) begin
            if (se0cnt != 2'd3) se0cnt <= se0cnt + 2'd1;
          end else if (ls_i == LS_J) begin
            st    <= ST_IDLE;
            prev  <= LS_J;
            eop_o <= (se0cnt >= 2'd2) && (bitcnt == 3'd0);
          end else begin
            st     <= ST_DROP;
            se0cnt <= 2'd0;
          end
        end
        ST_DROP: begin
          if (ls_i == LS_SE0) begin
            se0cnt <= 2'd1;
          end else if (ls_i == LS_J && se0cnt != 2'd0) begin
            st   <= ST_IDLE;
            prev <= LS_J;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  AST_BYTE_ON_STROBE: assert property (@(posedge clk) disable iff (rst)
    byte_stb_o |-> $past(bit_stb_i)); // R3
  AST_BYTE_IN_DATA: assert property (@(posedge clk) disable iff (rst)
    byte_stb_o |-> $past(st) == ST_DATA); // R2

endmodule

// File: rtl/usb_ls_token_check.sv
module usb_ls_token_check
  import usb_ls_rx_pkg::*;
#(
  parameter int EP_MAX = 2,
  parameter int EP_OW  = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  pkt_start_i,
  input  logic                  byte_stb_i,
  input  logic [7:0]            byte_i,
  input  logic                  eop_i,
  input  logic [TOK_ADDR_W:0]   cfg_i,
  output logic                  tok_valid_o,
  output logic [1:0]            tok_type_o,
  output logic [EP_OW-1:0]      tok_ep_o
);

  localparam logic [TOK_EP_W-1:0] EP_LIM = TOK_EP_W'(EP_MAX);

  logic [7:0]             pid, b1, b2;
  logic [1:0]             nb;
  logic                   extra;
  logic [TOK_FIELD_W-1:0] field;
  logic [TOK_ADDR_W-1:0]  addr;
  logic [TOK_EP_W-1:0]    ep;
  tok_kind_t              kind;
  logic                   pid_ok, crc_ok, accept;

  function automatic logic [4:0] crc5_walk(input logic [TOK_FIELD_W-1:0] d);
    logic [4:0] c;
    logic       fb;
    c = 5'h1f;
    for (int i = 0; i < TOK_FIELD_W; i++) begin
      fb = d[i] ^ c[4];
      c  = {c[3:0], 1'b0} ^ (fb ? CRC5_POLY : 5'b0);
    end
    return c;
  endfunction

  always_comb begin
    field  = {b2, b1};
    addr   = field[TOK_ADDR_W-1:0];
    ep     = field[TOK_ADDR_W +: TOK_EP_W];
    pid_ok = (pid[7:4] == ~pid[3:0]);
    case (pid[3:0])
      PID_OUT:   kind = TK_OUT;
      PID_IN:    kind = TK_IN;
      PID_SETUP: kind = TK_SETUP;
      default:   kind = TK_NONE;
    endcase
    crc_ok = (crc5_walk(field) == CRC5_RESIDUAL);
    accept = eop_i && (nb == 2'd3) && !extra && pid_ok && (kind != TK_NONE)
             && crc_ok && cfg_i[TOK_ADDR_W] && (addr == cfg_i[TOK_ADDR_W-1:0])
             && (ep <= EP_LIM);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pid <= '0; b1 <= '0; b2 <= '0;
      nb <= '0; extra <= 1'b0;
      tok_valid_o <= 1'b0;
      tok_type_o  <= '0;
      tok_ep_o    <= '0;
    end else begin
      if (pkt_start_i) begin
        nb    <= '0;
        extra <= 1'b0;
      end else if (byte_stb_i) begin
        case (nb)
          2'd0: pid <= byte_i;
          2'd1: b1  <= byte_i;
          2'd2: b2  <= byte_i;
          default: ;
        endcase
        if (nb == 2'd3) extra <= 1'b1;
        else            nb    <= nb + 2'd1;
      end
      tok_valid_o <= accept;
      if (accept) begin
        tok_type_o <= kind;
        tok_ep_o   <= ep[EP_OW-1:0];
      end
    end
  end

  AST_TOK_AT_EOP: assert property (@(posedge clk) disable iff (rst)
    tok_valid_o |-> $past(eop_i)); // R11
  AST_TOK_EP_RANGE: assert property (@(posedge clk) disable iff (rst)
    tok_valid_o |-> tok_ep_o <= EP_OW'(EP_MAX)); // R7
  AST_TOK_ENABLED: assert property (@(posedge clk) disable iff (rst)
    tok_valid_o |-> $past(cfg_i[TOK_ADDR_W])); // R5

endmodule

// File: rtl/usb_ls_token_rx.sv
module usb_ls_token_rx
  import usb_ls_rx_pkg::*;
#(
  parameter int SPB       = 4,
  parameter int STUFF_RUN = 6,
  parameter int EP_MAX    = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       dp_i,
  input  logic       dm_i,
  input  logic       cfg_wr_i,
  input  logic [7:0] cfg_wdata_i,
  output logic [7:0] cfg_o,
  output logic       tok_valid_o,
  output logic [1:0] tok_type_o,
  output logic [1:0] tok_ep_o,
  output logic       byte_valid_o,
  output logic [7:0] byte_data_o,
  output logic       byte_eop_o
);

  localparam int CFG_W = TOK_ADDR_W + 1;
  localparam int EP_OW = 2;

  logic [CFG_W-1:0] cfg_q;
  line_t            ls;
  logic             bit_stb, pkt_start, byte_stb, eop;
  logic [7:0]       rx_byte;

  always_ff @(posedge clk) begin
    if (rst)           cfg_q <= '0;
    else if (cfg_wr_i) cfg_q <= cfg_wdata_i;
  end
  assign cfg_o = cfg_q;

  usb_ls_line_sampler #(.SPB(SPB)) u_sampler (
    .clk(clk), .rst(rst), .dp_i(dp_i), .dm_i(dm_i),
    .ls_o(ls), .bit_stb_o(bit_stb)
  );

  usb_ls_bit_decoder #(.STUFF_RUN(STUFF_RUN), .SYNC_MIN_ZEROS(3)) u_decoder (
    .clk(clk), .rst(rst), .ls_i(ls), .bit_stb_i(bit_stb),
    .pkt_start_o(pkt_start), .byte_stb_o(byte_stb), .byte_o(rx_byte),
    .eop_o(eop)
  );

  usb_ls_token_check #(.EP_MAX(EP_MAX), .EP_OW(EP_OW)) u_token (
    .clk(clk), .rst(rst), .pkt_start_i(pkt_start), .byte_stb_i(byte_stb),
    .byte_i(rx_byte), .eop_i(eop), .cfg_i(cfg_q),
    .tok_valid_o(tok_valid_o), .tok_type_o(tok_type_o), .tok_ep_o(tok_ep_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      byte_valid_o <= 1'b0;
      byte_data_o  <= '0;
      byte_eop_o   <= 1'b0;
    end else begin
      byte_valid_o <= byte_stb & cfg_q[CFG_W-1];
      byte_eop_o   <= eop & cfg_q[CFG_W-1];
      if (byte_stb) byte_data_o <= rx_byte;
    end
  end

  AST_CFG_CLEARED: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> cfg_q == '0); // R6
  AST_BYTE_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
    byte_valid_o |-> $past(cfg_q[CFG_W-1])); // R5

endmodule

// File: tb/tb_usb_ls_token_rx.sv
`timescale 1ns/1ps
module tb_usb_ls_token_rx;

  localparam int SPB = 4;
  localparam int NVEC = 10;
  localparam logic [1:0] LJ = 2'b01, LK = 2'b10, LSE0 = 2'b00;

  logic clk = 1'b0, rst = 1'b1, dp = 1'b0, dm = 1'b1;
  logic cfg_wr = 1'b0;
  logic [7:0] cfg_wdata = '0;
  logic [7:0] cfg_o, byte_data;
  logic tok_valid, byte_valid, byte_eop;
  logic [1:0] tok_type, tok_ep;

  always #2.5 clk = ~clk;

  usb_ls_token_rx dut (
    .clk(clk), .rst(rst), .dp_i(dp), .dm_i(dm),
    .cfg_wr_i(cfg_wr), .cfg_wdata_i(cfg_wdata), .cfg_o(cfg_o),
    .tok_valid_o(tok_valid), .tok_type_o(tok_type), .tok_ep_o(tok_ep),
    .byte_valid_o(byte_valid), .byte_data_o(byte_data), .byte_eop_o(byte_eop)
  );

  // vector: {cfg[7:0], pid[3:0], addr[6:0], ep[3:0], corrupt_crc}
  localparam logic [23:0] VEC [0:NVEC-1] = '{
    {8'h85, 4'b0001, 7'h05, 4'd0, 1'b0},
    {8'h85, 4'b1001, 7'h05, 4'd1, 1'b0},
    {8'hA3, 4'b1101, 7'h23, 4'd2, 1'b0},
    {8'hA3, 4'b1001, 7'h23, 4'd3, 1'b0},
    {8'h85, 4'b1001, 7'h06, 4'd1, 1'b0},
    {8'h05, 4'b1001, 7'h05, 4'd1, 1'b0},
    {8'h85, 4'b0001, 7'h05, 4'd0, 1'b1},
    {8'hFF, 4'b1001, 7'h7F, 4'd2, 1'b0},
    {8'h80, 4'b1101, 7'h00, 4'd0, 1'b0},
    {8'h85, 4'b0101, 7'h05, 4'd0, 1'b0}
  };

  int checks = 0, fails = 0;
  int n_tok = 0, n_byte = 0, n_eop = 0;
  logic [1:0] l_type, l_ep;
  logic [7:0] mb [0:255];
  logic [7:0] pkt [0:7];
  bit bq [0:127];
  int nq;

  always @(negedge clk) begin
    if (!rst) begin
      if (tok_valid) begin n_tok++; l_type = tok_type; l_ep = tok_ep; end
      if (byte_valid) begin mb[n_byte[7:0]] = byte_data; n_byte++; end
      if (byte_eop) n_eop++;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  task automatic wcfg(input logic [7:0] v);
    @(negedge clk); cfg_wr = 1'b1; cfg_wdata = v;
    @(negedge clk); cfg_wr = 1'b0;
  endtask

  task automatic drive(input logic [1:0] lv, input int cyc);
    dp = lv[1]; dm = lv[0];
    repeat (cyc) @(negedge clk);
  endtask

  function automatic logic [1:0] flip(input logic [1:0] lv);
    return (lv == LJ) ? LK : LJ;
  endfunction

  task automatic send(input int nb, input int extra, input int nz,
                      input bit nostuff, input bit jit);
    logic [1:0] lv;
    int ones;
    nq = 0;
    for (int z = 0; z < nz; z++) begin bq[nq] = 1'b0; nq++; end
    bq[nq] = 1'b1; nq++;
    for (int i = 0; i < nb; i++)
      for (int k = 0; k < 8; k++) begin bq[nq] = pkt[i][k]; nq++; end
    for (int e = 0; e < extra; e++) begin bq[nq] = 1'b0; nq++; end
    lv = LJ; ones = 0;
    @(negedge clk);
    for (int q = 0; q < nq; q++) begin
      if (bq[q]) ones++;
      else begin lv = flip(lv); ones = 0; end
      drive(lv, jit ? ((q % 2) ? 3 : 5) : SPB);
      if (ones == 6 && !nostuff) begin
        lv = flip(lv); ones = 0;
        drive(lv, SPB);
      end
    end
    drive(LSE0, 2 * SPB);
    drive(LJ, 12 * SPB);
  endtask

  task automatic mk_token(input logic [3:0] pid, input logic [6:0] addr,
                          input logic [3:0] ep, input bit bad);
    logic [10:0] f;
    logic [4:0] c, tx;
    logic fb;
    f = {ep, addr};
    c = 5'h1f;
    for (int i = 0; i < 11; i++) begin
      fb = f[i] ^ c[4];
      c = {c[3:0], 1'b0} ^ (fb ? 5'b00101 : 5'b0);
    end
    tx = ~c;
    pkt[0] = {~pid, pid};
    pkt[1] = f[7:0];
    pkt[2] = {tx[0], tx[1], tx[2], tx[3], tx[4], f[10:8]};
    if (bad) pkt[2][7] = ~pkt[2][7];
  endtask

  initial begin
    int bt, bb, be;
    logic [7:0] cfg;
    logic [3:0] pid, ep;
    logic [6:0] addr;
    bit bad, en, istok, acc;
    int etype;
    string tag;

    repeat (10) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R6 reset state
    chk(cfg_o == 8'h00, "R6", "cfg after reset", cfg_o, 0);
    chk(!tok_valid && !byte_valid && !byte_eop, "R6", "outputs idle after reset",
        {tok_valid, byte_valid, byte_eop}, 0);

    // R5/R6: out of reset a token for address 0 gets no answer
    mk_token(4'b1001, 7'h00, 4'd0, 1'b0);
    bt = n_tok; bb = n_byte; be = n_eop;
    send(3, 0, 7, 1'b0, 1'b0);
    chk(n_tok == bt && n_byte == bb && n_eop == be, "R5",
        "silent while disabled after reset", n_tok - bt + n_byte - bb, 0);

    wcfg(8'hC2);
    @(negedge clk);
    chk(cfg_o == 8'hC2, "R6", "cfg readback", cfg_o, 8'hC2);

    // vector table
    for (int v = 0; v < NVEC; v++) begin
      {cfg, pid, addr, ep, bad} = VEC[v];
      wcfg(cfg);
      mk_token(pid, addr, ep, bad);
      en = cfg[7];
      istok = (pid == 4'b0001) || (pid == 4'b1001) || (pid == 4'b1101);
      acc = en && istok && !bad && (addr == cfg[6:0]) && (ep <= 4'd2);
      etype = (pid == 4'b0001) ? 0 : (pid == 4'b1001) ? 1 : 2;
      if (!en) tag = "R5";
      else if (bad) tag = "R9";
      else if (addr != cfg[6:0]) tag = "R10";
      else if (ep > 4'd2) tag = "R7";
      else if (!istok) tag = "R8";
      else tag = "R3";
      bt = n_tok; bb = n_byte; be = n_eop;
      send(3, 0, 7, 1'b0, 1'b0);
      chk((n_tok - bt) == int'(acc), tag, $sformatf("vec %0d accept count", v),
          n_tok - bt, int'(acc));
      if (acc) begin
        chk(int'(l_type) == etype, "R8", $sformatf("vec %0d type", v), l_type, etype);
        chk(l_ep == ep[1:0], "R7", $sformatf("vec %0d endpoint", v), l_ep, ep);
      end
      chk((n_byte - bb) == (en ? 3 : 0), tag, $sformatf("vec %0d byte count", v),
          n_byte - bb, en ? 3 : 0);
      if (en && (n_byte - bb) == 3)
        for (int i = 0; i < 3; i++)
          chk(mb[8'(bb + i)] == pkt[i], "R3", $sformatf("vec %0d byte %0d", v, i),
              mb[8'(bb + i)], pkt[i]);
      chk((n_eop - be) == (en ? 1 : 0), "R11", $sformatf("vec %0d eop", v),
          n_eop - be, en ? 1 : 0);
    end

    wcfg(8'h85);
    // R1: alternating 5/3 sample bits
    mk_token(4'b1001, 7'h05, 4'd2, 1'b0);
    bt = n_tok;
    send(3, 0, 7, 1'b0, 1'b1);
    chk(n_tok - bt == 1 && l_ep == 2'd2, "R1", "token under jitter", n_tok - bt, 1);

    // R4: stuffed data packet, bytes restored
    pkt[0] = 8'hC3; pkt[1] = 8'hFF; pkt[2] = 8'hFF; pkt[3] = 8'h00; pkt[4] = 8'h7E;
    bb = n_byte; be = n_eop;
    send(5, 0, 7, 1'b0, 1'b0);
    chk(n_byte - bb == 5, "R4", "stuffed packet byte count", n_byte - bb, 5);
    if (n_byte - bb == 5)
      chk(mb[8'(bb + 1)] == 8'hFF && mb[8'(bb + 2)] == 8'hFF && mb[8'(bb + 4)] == 8'h7E,
          "R4", "stuffed bytes restored", mb[8'(bb + 2)], 8'hFF);
    chk(n_eop - be == 1, "R4", "stuffed packet eop", n_eop - be, 1);

    // R4: stuffing violation drops the packet after the PID
    bb = n_byte; be = n_eop;
    send(3, 0, 7, 1'b1, 1'b0);
    chk(n_byte - bb == 1, "R4", "bytes before stuff error", n_byte - bb, 1);
    chk(n_eop - be == 0, "R4", "no eop after stuff error", n_eop - be, 0);

    // R11: packet ending mid-byte
    mk_token(4'b0001, 7'h05, 4'd0, 1'b0);
    bt = n_tok; be = n_eop;
    send(3, 3, 7, 1'b0, 1'b0);
    chk(n_tok == bt, "R11", "no token on mid-byte end", n_tok - bt, 0);
    chk(n_eop == be, "R11", "no eop on mid-byte end", n_eop - be, 0);

    // R8: PID nibbles not complementary
    mk_token(4'b1001, 7'h05, 4'd1, 1'b0);
    pkt[0] = 8'h19;
    bt = n_tok; bb = n_byte;
    send(3, 0, 7, 1'b0, 1'b0);
    chk(n_tok == bt && n_byte - bb == 3, "R8", "bad PID check ignored",
        n_tok - bt, 0);

    // R8: four-byte token
    mk_token(4'b1001, 7'h05, 4'd1, 1'b0);
    pkt[3] = 8'h00;
    bt = n_tok;
    send(4, 0, 7, 1'b0, 1'b0);
    chk(n_tok == bt, "R8", "over-long token ignored", n_tok - bt, 0);

    // R2: start pattern too short
    pkt[0] = 8'hFF; pkt[1] = 8'hFF; pkt[2] = 8'hFF;
    bb = n_byte; be = n_eop;
    send(3, 0, 1, 1'b0, 1'b0);
    chk(n_byte == bb && n_eop == be, "R2", "no bytes without start pattern",
        n_byte - bb, 0);

    // R2 positive after the short one
    mk_token(4'b1101, 7'h05, 4'd0, 1'b0);
    bt = n_tok;
    send(3, 0, 7, 1'b0, 1'b0);
    chk(n_tok - bt == 1 && l_type == 2'd2, "R2", "token after valid start",
        n_tok - bt, 1);

    summary();
  end

endmodule